// File: doc/BRIEF.md
# Command-Sequence Write Protection Unit

This unit sits beside the program path of a sector-programmed nonvolatile array. It watches every byte load (an address and data pair) and every program-cycle start, picks out the command sequences that are hidden in the load stream, and decides for each load window whether the array may be written. Three results are possible at the end of a window: the cycle goes ahead, it becomes a dummy cycle (the program timer runs so reads act as status polls, but nothing is written), or it is a chip erase.

Two protection mechanisms are combined. Software write protection, once switched on, demands the three-write unlock prefix at the start of every window. Two boot regions, the lowest and the highest 8 KB of the space, can each be locked for good by a seven-write sequence. Either lock also rejects chip erase. An identification mode returns fixed vendor and device codes and shows the state of each region lock. The protection flag and both locks model nonvolatile cells. The ordinary reset leaves them alone, and only a separate blank-part initialisation input clears them.

Top module: `cswp_top`

## Requirements
- R1: While `blank_n` is low, protection and both region locks are cleared. While `rst_n` is low, the sequence decoder, the window flags, identification mode and all outputs are cleared: `allow_prog`, `dummy_cycle`, `erase_go` and `id_active` read 0 and `id_data` reads 0x00.
- R2: With protection off and no lock hit, a window that holds at least one data load yields a one-cycle `allow_prog` pulse. The pulse comes in the cycle after `cyc_start`.
- R3: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 switch protection on. Data loaded later in that same window is allowed.
- R4: With protection on, a window of data loads that lacks the unlock prefix yields a `dummy_cycle` pulse and no `allow_prog`.
- R5: With protection on, the prefix must come before the first data load of the window. Prefix then data gives `allow_prog`. Data then prefix gives `dummy_cycle`.
- R6: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 switch protection off.
- R7: Protection and the locks survive assertion of `rst_n`.
- R8: The six-write form with final opcode 0x40, followed by a write of 0x00 to any address inside a boot region, locks only that region. A lock never clears except through `blank_n`.
- R9: A window whose data touches a locked region yields `dummy_cycle`, whatever the protection state. Data that stays outside the locked region is allowed.
- R10: The six-write form with final opcode 0x10 requests chip erase. At window end this gives `erase_go` if neither region is locked, and `dummy_cycle` otherwise.
- R11: The prefix with opcode 0x90 enters identification mode, and the prefix with 0xF0 leaves it. In the mode `id_active`=1 and `id_data` reads 0x1F at address 0x00000, 0xD5 at 0x00001, the lower lock at 0x00002 and the upper lock at 0x1FFF2. A lock reads 0xFE when the region is writable and 0xFF when it is locked. Any other address reads 0x00. Outside the mode `id_data` is 0x00.
- R12: A window made only of command writes produces no output pulse.
- R13: `allow_prog`, `dummy_cycle` and `erase_go` are single-cycle pulses, and at most one of them is high at a time.
- R14: A load that breaks a partly received sequence resets the decoder and counts as data. A load that is itself 0xAA@0x5555 restarts the prefix instead. A load that arrives in the same cycle as `cyc_start` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of volatile state |
| blank_n | input | 1 | Active-low blank-part initialisation of the protection flag and locks |
| ld_valid | input | 1 | Byte-load event strobe |
| ld_addr | input | 17 | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| cyc_start | input | 1 | End of load window / program-cycle start |
| rd_addr | input | 17 | Read address for identification data |
| allow_prog | output | 1 | Pulse: write the loaded sector |
| dummy_cycle | output | 1 | Pulse: start the timer, write nothing |
| erase_go | output | 1 | Pulse: chip erase accepted |
| id_active | output | 1 | Identification mode is active |
| id_data | output | 8 | Identification read data |

## Verification
A wrong protection flag or lock bit stays hidden until the next window closes. It then shows as `allow_prog` where `dummy_cycle` was due, or the other way round, one cycle after `cyc_start`. A lock bit can also be seen directly through the identification read in the same cycle. A decoder that loses its place shows only at window end, as a wrong verdict, so each sequence is checked by closing a window just after it. The reset test looks for protection that has survived, since a state that was cleared by mistake looks just like a new part until a protected window is tried.

// File: rtl/cswp_pkg.sv
package cswp_pkg;

    localparam logic [16:0] CMD_ADDR_A = 17'h05555;
    localparam logic [16:0] CMD_ADDR_B = 17'h02AAA;
    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  OP_PROT_ON = 8'hA0;
    localparam logic [7:0]  OP_EXTEND  = 8'h80;
    localparam logic [7:0]  OP_ID_ON   = 8'h90;
    localparam logic [7:0]  OP_ID_OFF  = 8'hF0;
    localparam logic [7:0]  OP_PROT_OFF = 8'h20;
    localparam logic [7:0]  OP_ERASE   = 8'h10;
    localparam logic [7:0]  OP_LOCK    = 8'h40;
    localparam logic [7:0]  LOCK_KEY   = 8'h00;
    localparam logic [7:0]  VENDOR_CODE = 8'h1F;
    localparam logic [7:0]  DEVICE_CODE = 8'hD5;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_P1, SQ_P2, SQ_X3, SQ_X4, SQ_X5, SQ_LK
    } seq_e;

    typedef struct packed {
        logic prot_on;
        logic prot_off;
        logic id_on;
        logic id_off;
        logic erase;
        logic lock_lo;
        logic lock_hi;
    } cmd_ev_t;

    typedef struct packed {
        seq_e seq;
        logic armed;
        logic data_seen;
        logic hit_lo;
        logic hit_hi;
        logic erase_req;
        logic id_mode;
        logic allow;
        logic dummy;
        logic erase;
    } vol_t;

    typedef struct packed {
        logic prot;
        logic lock_lo;
        logic lock_hi;
    } nv_t;

endpackage

// File: rtl/cswp_region_map.sv
module cswp_region_map #(
    parameter int ADDR_W = 17,
    parameter int BOOT_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        in_region
);
    localparam int TAG_W = ADDR_W - BOOT_W;

    for (genvar g = 0; g < 2; g++) begin : g_region
        localparam logic [TAG_W-1:0] TAG = (g == 0) ? '0 : '1;
        assign in_region[g] = (addr[ADDR_W-1:BOOT_W] == TAG);
    end
endmodule

// File: rtl/cswp_seq_decode.sv
module cswp_seq_decode
    import cswp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  seq_e              seq_q,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        in_region,
    output seq_e              seq_d,
    output logic              is_cmd,
    output cmd_ev_t           ev
);
    logic at_a, at_b, key_a, key_b;

    always_comb begin
        at_a  = (addr == ADDR_W'(CMD_ADDR_A));
        at_b  = (addr == ADDR_W'(CMD_ADDR_B));
        key_a = at_a && (data == DATA_W'(KEY_A));
        key_b = at_b && (data == DATA_W'(KEY_B));
        ev     = '0;
        is_cmd = 1'b1;
        seq_d  = SQ_IDLE;
        unique case (seq_q)
            SQ_P1: if (key_b) seq_d = SQ_P2;
                   else is_cmd = 1'b0;
            SQ_P2: begin
                if (at_a && data == DATA_W'(OP_PROT_ON))      ev.prot_on = 1'b1;
                else if (at_a && data == DATA_W'(OP_EXTEND))  seq_d = SQ_X3;
                else if (at_a && data == DATA_W'(OP_ID_ON))   ev.id_on = 1'b1;
                else if (at_a && data == DATA_W'(OP_ID_OFF))  ev.id_off = 1'b1;
                else is_cmd = 1'b0;
            end
            SQ_X3: if (key_a) seq_d = SQ_X4;
                   else is_cmd = 1'b0;
            SQ_X4: if (key_b) seq_d = SQ_X5;
                   else is_cmd = 1'b0;
            SQ_X5: begin
                if (at_a && data == DATA_W'(OP_PROT_OFF))     ev.prot_off = 1'b1;
                else if (at_a && data == DATA_W'(OP_ERASE))   ev.erase = 1'b1;
                else if (at_a && data == DATA_W'(OP_LOCK))    seq_d = SQ_LK;
                else is_cmd = 1'b0;
            end
            SQ_LK: begin
                if (data == DATA_W'(LOCK_KEY) && in_region[0])      ev.lock_lo = 1'b1;
                else if (data == DATA_W'(LOCK_KEY) && in_region[1]) ev.lock_hi = 1'b1;
                else is_cmd = 1'b0;
            end
            default: is_cmd = 1'b0;
        endcase
        // a first-key write always (re)starts the prefix
        if (!is_cmd && key_a) begin
            is_cmd = 1'b1;
            seq_d  = SQ_P1;
        end
    end
endmodule

// File: rtl/cswp_id_mux.sv
module cswp_id_mux
    import cswp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic [DATA_W-1:0] id_data
);
    localparam logic [ADDR_W-1:0] ID_VEND = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ID_DEV  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ID_LO   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ID_HI   = {{(ADDR_W-4){1'b1}}, 4'h2};

    always_comb begin
        id_data = '0;
        if (id_mode) begin
            if (rd_addr == ID_VEND)      id_data = DATA_W'(VENDOR_CODE);
            else if (rd_addr == ID_DEV)  id_data = DATA_W'(DEVICE_CODE);
            else if (rd_addr == ID_LO)   id_data = {{(DATA_W-1){1'b1}}, lock_lo};
            else if (rd_addr == ID_HI)   id_data = {{(DATA_W-1){1'b1}}, lock_hi};
        end
    end
endmodule

// File: rtl/cswp_top.sv
module cswp_top
    import cswp_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int BOOT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              allow_prog,
    output logic              dummy_cycle,
    output logic              erase_go,
    output logic              id_active,
    output logic [DATA_W-1:0] id_data
);
    vol_t    vol_d, vol_q;
    nv_t     nv_d, nv_q;
    logic [1:0] in_region;
    seq_e    dec_seq;
    logic    dec_cmd;
    cmd_ev_t dec_ev;
    logic    locked_hit;
    logic    prot_w, lock_lo_w, lock_hi_w;

    cswp_region_map #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_map (
        .addr      (ld_addr),
        .in_region (in_region)
    );

    cswp_seq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .seq_q     (vol_q.seq),
        .addr      (ld_addr),
        .data      (ld_data),
        .in_region (in_region),
        .seq_d     (dec_seq),
        .is_cmd    (dec_cmd),
        .ev        (dec_ev)
    );

    cswp_id_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_id (
        .id_mode (vol_q.id_mode),
        .rd_addr (rd_addr),
        .lock_lo (nv_q.lock_lo),
        .lock_hi (nv_q.lock_hi),
        .id_data (id_data)
    );

    always_comb begin
        vol_d       = vol_q;
        nv_d        = nv_q;
        vol_d.allow = 1'b0;
        vol_d.dummy = 1'b0;
        vol_d.erase = 1'b0;
        locked_hit  = (vol_q.hit_lo && nv_q.lock_lo) || (vol_q.hit_hi && nv_q.lock_hi);
        if (cyc_start) begin
            if (vol_q.erase_req) begin
                if (nv_q.lock_lo || nv_q.lock_hi) vol_d.dummy = 1'b1;
                else                              vol_d.erase = 1'b1;
            end else if (vol_q.data_seen) begin
                if ((nv_q.prot && !vol_q.armed) || locked_hit) vol_d.dummy = 1'b1;
                else                                           vol_d.allow = 1'b1;
            end
            vol_d.seq       = SQ_IDLE;
            vol_d.armed     = 1'b0;
            vol_d.data_seen = 1'b0;
            vol_d.hit_lo    = 1'b0;
            vol_d.hit_hi    = 1'b0;
            vol_d.erase_req = 1'b0;
        end else if (ld_valid) begin
            vol_d.seq = dec_seq;
            if (dec_ev.prot_on) begin
                nv_d.prot = 1'b1;
                if (!vol_q.data_seen) vol_d.armed = 1'b1;
            end
            if (dec_ev.prot_off) nv_d.prot      = 1'b0;
            if (dec_ev.id_on)    vol_d.id_mode  = 1'b1;
            if (dec_ev.id_off)   vol_d.id_mode  = 1'b0;
            if (dec_ev.erase)    vol_d.erase_req = 1'b1;
            if (dec_ev.lock_lo)  nv_d.lock_lo   = 1'b1;
            if (dec_ev.lock_hi)  nv_d.lock_hi   = 1'b1;
            if (!dec_cmd) begin
                vol_d.data_seen = 1'b1;
                vol_d.hit_lo    = vol_q.hit_lo | in_region[0];
                vol_d.hit_hi    = vol_q.hit_hi | in_region[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q <= '{seq: SQ_IDLE, default: 1'b0};
        else        vol_q <= vol_d;
    end

    // nonvolatile cells: only the blank-part input clears them
    always_ff @(posedge clk or negedge blank_n) begin
        if (!blank_n) nv_q <= '0;
        else          nv_q <= nv_d;
    end

    assign allow_prog  = vol_q.allow;
    assign dummy_cycle = vol_q.dummy;
    assign erase_go    = vol_q.erase;
    assign id_active   = vol_q.id_mode;
    assign prot_w      = nv_q.prot;
    assign lock_lo_w   = nv_q.lock_lo;
    assign lock_hi_w   = nv_q.lock_hi;
endmodule

// File: rtl/cswp_chk.sv
module cswp_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank_n,
    input logic              ld_valid,
    input logic              cyc_start,
    input logic              allow_prog,
    input logic              dummy_cycle,
    input logic              erase_go,
    input logic              id_active,
    input logic [DATA_W-1:0] id_data,
    input logic              prot,
    input logic              lock_lo,
    input logic              lock_hi
);
    p_one_verdict_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({allow_prog, dummy_cycle, erase_go}));

    p_verdict_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_prog || dummy_cycle || erase_go) |-> $past(cyc_start));

    p_prot_moves_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        !$stable(prot) |-> $past(ld_valid));

    p_lock_lo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        !$fell(lock_lo));

    p_lock_hi_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        !$fell(lock_hi));

    p_erase_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n || !blank_n)
        erase_go |-> !(lock_lo || lock_hi));

    p_id_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !id_active |-> (id_data == '0));
endmodule

bind cswp_top cswp_chk #(.DATA_W(DATA_W)) u_cswp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank_n     (blank_n),
    .ld_valid    (ld_valid),
    .cyc_start   (cyc_start),
    .allow_prog  (allow_prog),
    .dummy_cycle (dummy_cycle),
    .erase_go    (erase_go),
    .id_active   (id_active),
    .id_data     (id_data),
    .prot        (prot_w),
    .lock_lo     (lock_lo_w),
    .lock_hi     (lock_hi_w)
);

// File: tb/cswp_top_tb_top.sv
module cswp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blank_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [16:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        cyc_start = 1'b0;
    logic [16:0] rd_addr = '0;
    logic        allow_prog, dummy_cycle, erase_go, id_active;
    logic [7:0]  id_data;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cswp_top dut_i (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_data(ld_data), .cyc_start(cyc_start),
        .rd_addr(rd_addr), .allow_prog(allow_prog), .dummy_cycle(dummy_cycle),
        .erase_go(erase_go), .id_active(id_active), .id_data(id_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic prefix(input logic [7:0] op);
        load(17'h05555, 8'hAA);
        load(17'h02AAA, 8'h55);
        load(17'h05555, op);
    endtask

    task automatic ext(input logic [7:0] op);
        prefix(8'h80);
        load(17'h05555, 8'hAA);
        load(17'h02AAA, 8'h55);
        load(17'h05555, op);
    endtask

    // close window; verdict is registered at the edge after cyc_start
    task automatic close(input string tag, input int ea, input int ed, input int ee);
        @(negedge clk);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk({tag, " verdict"}, {allow_prog, dummy_cycle, erase_go}, {ea[0], ed[0], ee[0]});
        @(negedge clk);
        chk("R13 pulse width", {allow_prog, dummy_cycle, erase_go}, 0);
    endtask

    task automatic id_read(input string tag, input logic [16:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(tag, id_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {allow_prog, dummy_cycle, erase_go, id_active}, 0);
        chk("R1 reset id_data", id_data, 0);
    endtask

    task automatic t_plain();
        load(17'h04000, 8'h12);
        load(17'h04001, 8'h34);
        close("R2 unprotected data", 1, 0, 0);
    endtask

    task automatic t_ident();
        prefix(8'h90);
        close("R12 command-only window", 0, 0, 0);
        chk("R11 id_active on", id_active, 1);
        id_read("R11 vendor code", 17'h00000, 8'h1F);
        id_read("R11 device code", 17'h00001, 8'hD5);
        id_read("R11 lower unlocked", 17'h00002, 8'hFE);
        id_read("R11 upper unlocked", 17'h1FFF2, 8'hFE);
        id_read("R11 other address", 17'h00005, 8'h00);
        prefix(8'hF0);
        close("R12 id exit window", 0, 0, 0);
        chk("R11 id_active off", id_active, 0);
        id_read("R11 quiet outside mode", 17'h00000, 8'h00);
    endtask

    task automatic t_enable();
        prefix(8'hA0);
        load(17'h06000, 8'h77);
        close("R3 enable with data", 1, 0, 0);
    endtask

    task automatic t_protected();
        load(17'h06000, 8'h01);
        close("R4 no prefix", 0, 1, 0);
        prefix(8'hA0);
        load(17'h06001, 8'h02);
        close("R5 prefix first", 1, 0, 0);
        load(17'h06002, 8'h03);
        prefix(8'hA0);
        close("R5 prefix late", 0, 1, 0);
    endtask

    task automatic t_persist();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        load(17'h06003, 8'h04);
        close("R7 protection survives reset", 0, 1, 0);
    endtask

    task automatic t_broken();
        load(17'h05555, 8'hAA);
        load(17'h02AAA, 8'h55);
        load(17'h05555, 8'h33);
        close("R14 broken prefix is data", 0, 1, 0);
        load(17'h05555, 8'hAA);
        prefix(8'hA0);
        load(17'h06004, 8'h05);
        close("R14 key restarts prefix", 1, 0, 0);
        @(negedge clk);
        cyc_start = 1'b1; ld_valid = 1'b1; ld_addr = 17'h06005; ld_data = 8'h06;
        @(negedge clk);
        cyc_start = 1'b0; ld_valid = 1'b0;
        close("R14 load with cyc_start dropped", 0, 0, 0);
    endtask

    task automatic t_disable();
        ext(8'h20);
        close("R6 disable window", 0, 0, 0);
        load(17'h06006, 8'h07);
        close("R6 unprotected after disable", 1, 0, 0);
    endtask

    task automatic t_lock();
        ext(8'h10);
        close("R10 erase unlocked", 0, 0, 1);
        ext(8'h40);
        load(17'h00100, 8'h00);
        close("R8 lock window", 0, 0, 0);
        prefix(8'h90);
        close("R12 id entry", 0, 0, 0);
        id_read("R8 lower locked", 17'h00002, 8'hFF);
        id_read("R8 upper still open", 17'h1FFF2, 8'hFE);
        prefix(8'hF0);
        close("R12 id exit", 0, 0, 0);
        load(17'h00400, 8'h09);
        close("R9 locked region write", 0, 1, 0);
        load(17'h1E000, 8'h0A);
        close("R9 other region allowed", 1, 0, 0);
        load(17'h08000, 8'h0B);
        load(17'h01FFF, 8'h0C);
        close("R9 mixed window blocked", 0, 1, 0);
        ext(8'h10);
        close("R10 erase rejected when locked", 0, 1, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        load(17'h00400, 8'h0D);
        close("R7 lock survives reset", 0, 1, 0);
    endtask

    task automatic t_blank();
        @(negedge clk); blank_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); blank_n = 1'b1; rst_n = 1'b1;
        load(17'h00400, 8'h0E);
        close("R1 blank clears lock", 1, 0, 0);
        prefix(8'h90);
        close("R12 id entry after blank", 0, 0, 0);
        id_read("R1 blank lower reads open", 17'h00002, 8'hFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        blank_n = 1'b1;
        rst_n   = 1'b1;
        t_plain();
        t_ident();
        t_enable();
        t_protected();
        t_persist();
        t_broken();
        t_disable();
        t_lock();
        t_blank();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule